// File: doc/BRIEF.md
# Exposure Zebra Overlay Generator

This block sits in a display pixel path and marks regions of an image that are clipped bright or crushed dark. For each incoming pixel (luma plus two chroma channels, with its screen column, screen row and a frame counter) it decides whether the luma crosses one of two programmable limits. If the pixel also lies inside a moving stripe or dot pattern, the block blends it toward a shared highlight colour. Otherwise the pixel passes through unchanged.

Two detectors, one for highlights and one for shadows, are enabled independently. Each detector has its own 24-bit setting word that gives its limit, pattern shape, animation speed and blend strength. A per-pixel flag from the layer compositor tells the block whether the pixel's source layer allows the effect. Pixels from other layers are never marked. The result appears a fixed two clock cycles after the input.

Top module: `zebra_overlay`

## Requirements
- R1: While reset is asserted and until the first valid pixel has had time to pass the pipeline, `out_valid` is 0 and all three output channels read 0.
- R2: A pixel accepted with `in_valid`=1 appears on the outputs with `out_valid`=1 exactly two rising clock edges later, and back-to-back pixels come out back to back in input order.
- R3: The highlight detector matches when its enable bit (bit 0 of `over_cfg`) is 1 and luma is greater than or equal to its limit in `over_cfg[23:16]`.
- R4: The shadow detector matches when bit 0 of `under_cfg` is 1 and luma is less than or equal to its limit in `under_cfg[15:8]`. Bits [15:8] of `over_cfg` have no effect on the highlight detector.
- R5: When both detectors match, the highlight word supplies the style, speed and opacity that are used.
- R6: When `in_layer_zebra` is 0, the pixel leaves the block unchanged whatever the settings are.
- R7: Style field bits [3:2] select the pattern from the phase s = (x + y + frame·step) mod 8. Code 1 marks s<2 (thin lines). Code 2 marks s<4 (thick lines). Codes 0 and 3 both mark s=0 on even rows only (dots).
- R8: Speed bit 1 selects the step: 0 gives step 1 (slow) and 1 gives step 4 (fast).
- R9: A marked pixel becomes p + floor((c − p)·k/16) on each channel, where k is the opacity field bits [7:4] and c is the colour from `hl_color` (luma [23:16], Cb [15:8], Cr [7:0]). When k=0 the pixel is unchanged.
- R10: When neither detector is enabled, every pixel passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel qualifier |
| in_y | input | 8 | Input luma |
| in_cb | input | 8 | Input blue-difference chroma |
| in_cr | input | 8 | Input red-difference chroma |
| in_x | input | 12 | Pixel column |
| in_row | input | 12 | Pixel row |
| in_frame | input | 8 | Frame counter |
| in_layer_zebra | input | 1 | Source layer permits the effect |
| over_cfg | input | 24 | Highlight detector setting word |
| under_cfg | input | 24 | Shadow detector setting word |
| hl_color | input | 24 | Shared highlight colour |
| out_valid | output | 1 | Output pixel qualifier |
| out_y | output | 8 | Output luma |
| out_cb | output | 8 | Output blue-difference chroma |
| out_cr | output | 8 | Output red-difference chroma |

## Verification
The hardest case to reach is a pixel that matches both detectors while the two patterns disagree about whether its position is marked. Only then does the priority of the highlight detector show at the outputs. The stimulus makes the highlight limit 0 and the shadow limit 255, so both detectors match. It then picks a frame count where the slow thick pattern of the highlight word marks the pixel and the fast thick pattern of the shadow word does not. A dot-style vector with an odd row and phase zero, and the speed pair that differ only in their step, also separate alternatives that would otherwise look the same.

// File: rtl/zebra_pkg.sv
package zebra_pkg;

  typedef enum logic [1:0] {
    STY_DOTS     = 2'd0,
    STY_THIN     = 2'd1,
    STY_THICK    = 2'd2,
    STY_DOTS_ALT = 2'd3
  } zstyle_e;

  // Setting word, bit 0 at the bottom
  typedef struct packed {
    logic [7:0] over_th;   // [23:16]
    logic [7:0] under_th;  // [15:8]
    logic [3:0] opacity;   // [7:4]
    zstyle_e    style;     // [3:2]
    logic       fast;      // [1]
    logic       enable;    // [0]
  } zcfg_t;

  localparam int unsigned PHASE_BITS = 3;
  localparam int unsigned OPA_BITS   = 4;

endpackage

// File: rtl/zebra_classify.sv
module zebra_classify
  import zebra_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] luma,
  input  logic          layer_en,
  input  zcfg_t         over_c,
  input  zcfg_t         under_c,
  output logic          match,
  output zcfg_t         win_c
);
  logic over_m;
  logic under_m;

  always_comb begin
    over_m  = over_c.enable  && (luma >= over_c.over_th);
    under_m = under_c.enable && (luma <= under_c.under_th);
    match   = layer_en && (over_m || under_m);
    win_c   = over_m ? over_c : under_c;
  end
endmodule

// File: rtl/zebra_pattern.sv
module zebra_pattern
  import zebra_pkg::*;
#(
  parameter int unsigned PW = 12,
  parameter int unsigned FW = 8
) (
  input  logic [PW-1:0] pos_x,
  input  logic [PW-1:0] pos_y,
  input  logic [FW-1:0] frame,
  input  zstyle_e       style,
  input  logic          fast,
  output logic          lit
);
  logic [PHASE_BITS-1:0] step_off;
  logic [PHASE_BITS-1:0] phase;

  always_comb begin
    step_off = fast ? {frame[0], 2'b00} : frame[PHASE_BITS-1:0];
    phase    = pos_x[PHASE_BITS-1:0] + pos_y[PHASE_BITS-1:0] + step_off;
    unique case (style)
      STY_THIN:  lit = (phase < 3'd2);
      STY_THICK: lit = (phase < 3'd4);
      default:   lit = (phase == 3'd0) && !pos_y[0];
    endcase
  end
endmodule

// File: rtl/zebra_blend.sv
module zebra_blend
  import zebra_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0]       pix,
  input  logic [DW-1:0]       col,
  input  logic [OPA_BITS-1:0] opa,
  output logic [DW-1:0]       res
);
  localparam int unsigned PRW = DW + OPA_BITS + 1;

  logic signed [DW:0]    diff;
  logic signed [PRW-1:0] prod;
  logic signed [PRW-1:0] scaled;
  logic signed [PRW-1:0] sum;

  always_comb begin
    diff   = $signed({1'b0, col}) - $signed({1'b0, pix});
    prod   = diff * $signed({1'b0, opa});
    scaled = prod >>> OPA_BITS;
    sum    = $signed({{(PRW-DW){1'b0}}, pix}) + scaled;
    res    = sum[DW-1:0];
  end

  always_comb begin
    AST_BLEND_BOUNDED: assert ((res >= ((pix < col) ? pix : col)) &&
                               (res <= ((pix < col) ? col : pix))); // R9
  end
endmodule

// File: rtl/zebra_overlay.sv
module zebra_overlay
  import zebra_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned PW = 12,
  parameter int unsigned FW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [DW-1:0]   in_y,
  input  logic [DW-1:0]   in_cb,
  input  logic [DW-1:0]   in_cr,
  input  logic [PW-1:0]   in_x,
  input  logic [PW-1:0]   in_row,
  input  logic [FW-1:0]   in_frame,
  input  logic            in_layer_zebra,
  input  logic [23:0]     over_cfg,
  input  logic [23:0]     under_cfg,
  input  logic [3*DW-1:0] hl_color,
  output logic            out_valid,
  output logic [DW-1:0]   out_y,
  output logic [DW-1:0]   out_cb,
  output logic [DW-1:0]   out_cr
);
  localparam int unsigned NCH = 3;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  // detection and pattern
  zcfg_t over_c, under_c, win_c;
  logic  det_match, pat_lit;

  assign over_c  = zcfg_t'(over_cfg);
  assign under_c = zcfg_t'(under_cfg);

  zebra_classify #(.DW(DW)) u_classify (
    .luma     (in_y),
    .layer_en (in_layer_zebra),
    .over_c   (over_c),
    .under_c  (under_c),
    .match    (det_match),
    .win_c    (win_c)
  );

  zebra_pattern #(.PW(PW), .FW(FW)) u_pattern (
    .pos_x (in_x),
    .pos_y (in_row),
    .frame (in_frame),
    .style (win_c.style),
    .fast  (win_c.fast),
    .lit   (pat_lit)
  );

  // stage 1
  logic                s1_valid_q, s1_valid_d;
  logic [NCH*DW-1:0]   s1_pix_q,   s1_pix_d;
  logic                s1_hit_q,   s1_hit_d;
  logic [OPA_BITS-1:0] s1_opa_q,   s1_opa_d;
  logic                s1_en;

  always_comb begin
    s1_en      = in_valid;
    s1_valid_d = in_valid;
    s1_pix_d   = {in_y, in_cb, in_cr};
    s1_hit_d   = det_match && pat_lit;
    s1_opa_d   = win_c.opacity;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      s1_valid_q <= 1'b0;
      s1_pix_q   <= '0;
      s1_hit_q   <= 1'b0;
      s1_opa_q   <= '0;
    end else begin
      s1_valid_q <= s1_valid_d;
      if (s1_en) begin
        s1_pix_q <= s1_pix_d;
        s1_hit_q <= s1_hit_d;
        s1_opa_q <= s1_opa_d;
      end
    end
  end

  // stage 2: blend per channel
  logic [NCH*DW-1:0] mix;
  logic [NCH*DW-1:0] s2_pix_q, s2_pix_d;
  logic              s2_valid_q;
  logic              s2_en;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    zebra_blend #(.DW(DW)) u_blend (
      .pix (s1_pix_q[ch*DW +: DW]),
      .col (hl_color[ch*DW +: DW]),
      .opa (s1_opa_q),
      .res (mix[ch*DW +: DW])
    );
  end

  always_comb begin
    s2_en    = s1_valid_q;
    s2_pix_d = s1_hit_q ? mix : s1_pix_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      s2_valid_q <= 1'b0;
      s2_pix_q   <= '0;
    end else begin
      s2_valid_q <= s1_valid_q;
      if (s2_en) s2_pix_q <= s2_pix_d;
    end
  end

  assign out_valid = s2_valid_q;
  assign out_y     = s2_pix_q[2*DW +: DW];
  assign out_cb    = s2_pix_q[DW +: DW];
  assign out_cr    = s2_pix_q[0 +: DW];

  AST_TWO_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |-> ##2 out_valid); // R2

  AST_LAYER_GATE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && !in_layer_zebra) |-> ##2
      ({out_y, out_cb, out_cr} == $past({in_y, in_cb, in_cr}, 2))); // R6

  AST_DISABLED_PASS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && !over_cfg[0] && !under_cfg[0]) |-> ##2
      ({out_y, out_cb, out_cr} == $past({in_y, in_cb, in_cr}, 2))); // R10

  AST_ZERO_OPACITY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (s1_valid_q && s1_opa_q == '0) |=>
      ({out_y, out_cb, out_cr} == $past(s1_pix_q))); // R9
endmodule

// File: tb/zebra_overlay_tb_top.sv
module zebra_overlay_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;
  localparam logic [23:0] COLOR = 24'hC86432;

  typedef struct packed {
    logic [7:0]  luma;
    logic [7:0]  cb;
    logic [7:0]  cr;
    logic [7:0]  x;
    logic [7:0]  row;
    logic [7:0]  fr;
    logic        layer;
    logic [23:0] ocfg;
    logic [23:0] ucfg;
    logic        hit;
    logic [3:0]  opa;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{8'd250, 8'd128, 8'd128, 8'd0, 8'd0, 8'd0, 1'b1, 24'hC80085, 24'h000000, 1'b1, 4'd8},  // R3 R7 thin hit
    '{8'd250, 8'd128, 8'd128, 8'd3, 8'd0, 8'd0, 1'b1, 24'hC80085, 24'h000000, 1'b0, 4'd0},  // R7 thin gap
    '{8'd199, 8'd60,  8'd200, 8'd0, 8'd0, 8'd0, 1'b1, 24'hC80085, 24'h000000, 1'b0, 4'd0},  // R3 below limit
    '{8'd200, 8'd60,  8'd200, 8'd1, 8'd0, 8'd0, 1'b1, 24'hC80085, 24'h000000, 1'b1, 4'd8},  // R3 equal limit
    '{8'd30,  8'd20,  8'd240, 8'd1, 8'd1, 8'd0, 1'b1, 24'h000000, 24'h001EFB, 1'b1, 4'd15}, // R4 equal limit
    '{8'd31,  8'd20,  8'd240, 8'd1, 8'd1, 8'd0, 1'b1, 24'h000000, 24'h001EFB, 1'b0, 4'd0},  // R4 above limit
    '{8'd10,  8'd90,  8'd90,  8'd0, 8'd1, 8'd1, 1'b1, 24'h000000, 24'h001EFB, 1'b0, 4'd0},  // R8 fast
    '{8'd10,  8'd90,  8'd90,  8'd0, 8'd1, 8'd1, 1'b1, 24'h000000, 24'h001EF9, 1'b1, 4'd15}, // R8 slow
    '{8'd250, 8'd128, 8'd128, 8'd0, 8'd0, 8'd0, 1'b0, 24'hC80085, 24'h000000, 1'b0, 4'd0},  // R6 layer off
    '{8'd100, 8'd128, 8'd128, 8'd0, 8'd0, 8'd0, 1'b1, 24'hC8FF85, 24'h000000, 1'b0, 4'd0},  // R4 field ignored
    '{8'd128, 8'd10,  8'd250, 8'd0, 8'd0, 8'd1, 1'b1, 24'h000049, 24'h00FFFB, 1'b1, 4'd4},  // R5 priority
    '{8'd255, 8'd128, 8'd128, 8'd0, 8'd0, 8'd0, 1'b1, 24'hC800F1, 24'h000000, 1'b1, 4'd15}, // R7 dot
    '{8'd255, 8'd128, 8'd128, 8'd7, 8'd1, 8'd0, 1'b1, 24'hC800F1, 24'h000000, 1'b0, 4'd0},  // R7 dot odd row
    '{8'd255, 8'd50,  8'd50,  8'd6, 8'd2, 8'd0, 1'b1, 24'hC800F1, 24'h000000, 1'b1, 4'd15}, // R7 dot even row
    '{8'd255, 8'd50,  8'd50,  8'd6, 8'd2, 8'd0, 1'b1, 24'hC800FD, 24'h000000, 1'b1, 4'd15}, // R7 code 3
    '{8'd255, 8'd50,  8'd50,  8'd1, 8'd0, 8'd0, 1'b1, 24'hC800FD, 24'h000000, 1'b0, 4'd0},  // R7 code 3 gap
    '{8'd250, 8'd128, 8'd128, 8'd0, 8'd0, 8'd0, 1'b1, 24'hC80005, 24'h000000, 1'b1, 4'd0},  // R9 opacity 0
    '{8'd250, 8'd128, 8'd128, 8'd0, 8'd0, 8'd0, 1'b1, 24'hC80084, 24'h000000, 1'b0, 4'd0},  // R10 disabled
    '{8'd250, 8'd128, 8'd128, 8'd3, 8'd0, 8'd0, 1'b1, 24'hC80089, 24'h000000, 1'b1, 4'd8}   // R7 thick
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [7:0]  in_y, in_cb, in_cr;
  logic [11:0] in_x, in_row;
  logic [7:0]  in_frame;
  logic        in_layer_zebra;
  logic [23:0] over_cfg, under_cfg;
  logic        out_valid;
  logic [7:0]  out_y, out_cb, out_cr;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  zebra_overlay dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .in_y           (in_y),
    .in_cb          (in_cb),
    .in_cr          (in_cr),
    .in_x           (in_x),
    .in_row         (in_row),
    .in_frame       (in_frame),
    .in_layer_zebra (in_layer_zebra),
    .over_cfg       (over_cfg),
    .under_cfg      (under_cfg),
    .hl_color       (COLOR),
    .out_valid      (out_valid),
    .out_y          (out_y),
    .out_cb         (out_cb),
    .out_cr         (out_cr)
  );

  function automatic logic [7:0] mixc(input logic [7:0] p, input logic [7:0] c,
                                      input logic hit, input logic [3:0] k);
    int d;
    if (!hit) return p;
    d = (int'(c) - int'(p)) * int'(k);
    return 8'(int'(p) + (d >>> 4));
  endfunction

  function automatic logic [24:0] expect_of(input vec_t v);
    return {1'b1, mixc(v.luma, COLOR[23:16], v.hit, v.opa),
                  mixc(v.cb,   COLOR[15:8],  v.hit, v.opa),
                  mixc(v.cr,   COLOR[7:0],   v.hit, v.opa)};
  endfunction

  task automatic check(input string req, input logic [24:0] exp);
    logic [24:0] act;
    act = {out_valid, out_y, out_cb, out_cr};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    in_valid       = 1'b1;
    in_y           = v.luma;
    in_cb          = v.cb;
    in_cr          = v.cr;
    in_x           = {4'd0, v.x};
    in_row         = {4'd0, v.row};
    in_frame       = v.fr;
    in_layer_zebra = v.layer;
    over_cfg       = v.ocfg;
    under_cfg      = v.ucfg;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected under %0d", cycles, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0; in_y = '0; in_cb = '0; in_cr = '0;
    in_x = '0; in_row = '0; in_frame = '0; in_layer_zebra = 1'b0;
    over_cfg = '0; under_cfg = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 in reset", 25'd0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 after release", 25'd0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check($sformatf("R9 vector %0d", i), expect_of(VEC[i]));
    end

    // R2: back-to-back stream of three vectors
    for (int k = 0; k < 6; k++) begin
      if (k == 1 || k == 5) check("R2 idle slot", {1'b0, out_y, out_cb, out_cr});
      else if (k >= 2) check($sformatf("R2 stream slot %0d", k), expect_of(VEC[k-2]));
      if (k < 3) drive(VEC[k]);
      else in_valid = 1'b0;
      @(posedge clk);
      @(negedge clk);
    end

    // R1: reset in mid-stream clears outputs
    drive(VEC[0]);
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    check("R1 reset mid-stream", 25'd0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule